// File: doc/BRIEF.md
# E1 Single-Timeslot Drop/Insert Port

This block adds an auxiliary serial port to a 32-slot, 2.048 Mb/s E1 bit stream. In single-slot mode it takes one chosen 8-bit slot out of the received stream and presents it as a 64 kb/s serial output. On the transmit side it puts a 64 kb/s auxiliary input into the same slot. In pass-through mode it copies every received bit to the drop output, and the main transmit stream goes to the line unchanged.

The block runs on a fast system clock. A one-cycle strobe, `bit_en_i`, marks each 2.048 MHz bit period, and `frame_start_i` marks bit 0 of slot 0. The port clocks are not generated clocks. They are clock-enable strobes:

- `drop_stb_o` is one 64 kHz burst of eight pulses per frame in single-slot mode, and a 2.048 MHz strobe in pass-through mode.
- `ins_stb_o` marks the edges on which `aux_bit_i` is sampled.

A small configuration register holds the mode bit and the slot number. The active copy of that register is reloaded only at a frame boundary.

The mode controller has three states:

- `ST_WAIT`: the state after reset, with no frame alignment seen yet.
- `ST_FULL`: whole-stream pass-through.
- `ST_SLOT`: single-slot drop and insert.

It has the following transitions:

- `ST_WAIT` to `ST_FULL` or `ST_SLOT` on the first frame-start bit.
- At every later frame boundary, `ST_FULL` and `ST_SLOT` each move to `ST_FULL` or `ST_SLOT`, as the pending mode bit selects.
- Between boundaries each state holds.

Top module: `e1_dip_port`

## Requirements
- R1: After reset and until the first bit strobe with `frame_start_i` high, the state is waiting. In that state `drop_stb_o` and `ins_stb_o` stay low, and `tx_line_o` takes the value of `tx_bit_i` one cycle after each bit strobe.
- R2: The pending configuration resets to mode bit 1 (single-slot) and slot 0, which is the value 80h of an 8-bit word with the mode in bit 7 and the slot in bits 4..0. The first aligned frame after reset therefore drops and inserts slot 0.
- R3: In pass-through mode (mode bit 0), each bit strobe produces a `drop_stb_o` pulse one cycle later, with `drop_bit_o` equal to that bit's `rx_bit_i`. This gives 256 pulses per frame. `ins_stb_o` never rises, and `tx_line_o` follows `tx_bit_i`.
- R4: In single-slot mode (mode bit 1), exactly 8 `drop_stb_o` pulses occur per frame, all during the selected slot. The drop bits come out in line order, so the first one is the slot's MSB.
- R5: In single-slot mode, `ins_stb_o` is high in the same cycle as each bit strobe of the selected slot. `tx_line_o` carries the `aux_bit_i` sampled on that edge, one cycle later. Every other slot carries `tx_bit_i`.
- R6: Slot 0 bit 0 is the bit strobed together with `frame_start_i`. Slot s occupies bit strobes 8s to 8s+7. After slot 31 bit 7, the position wraps to slot 0 bit 0 without needing `frame_start_i`.
- R7: A configuration write takes effect only at the next frame boundary (slot 0 bit 0). A write in the same cycle as a boundary bit applies from the frame after, so no slot is ever cut short.
- R8: `drop_stb_o` is a single-cycle pulse that only follows a cycle with `bit_en_i` high. `ins_stb_o` is only high together with `bit_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en_i | input | 1 | One-cycle strobe for each 2.048 MHz bit period |
| frame_start_i | input | 1 | High with the bit strobe of slot 0 bit 0 |
| rx_bit_i | input | 1 | Received line bit, valid with `bit_en_i` |
| tx_bit_i | input | 1 | Main transmit data bit, valid with `bit_en_i` |
| aux_bit_i | input | 1 | Auxiliary 64 kb/s input bit, sampled when `ins_stb_o` is high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Mode bit to write: 1 selects single-slot mode, 0 selects pass-through |
| cfg_slot_i | input | 5 | Slot number to write |
| drop_bit_o | output | 1 | Dropped data bit |
| drop_stb_o | output | 1 | Drop clock-enable, high when `drop_bit_o` is new |
| ins_stb_o | output | 1 | Insert clock-enable, marks the `aux_bit_i` sampling edge |
| tx_line_o | output | 1 | Transmit line bit |

## Verification
A configuration write and the frame-boundary reload can occur on the same edge. The bench provokes this by asserting `cfg_we_i` together with the `frame_start_i` bit strobe. It then judges that the frame just starting still uses the old slot and mode, and that the new value shows only one frame later. The bench also writes a new slot during bit 3 of the slot currently selected, and expects all eight drop pulses of that slot to still appear.

// File: rtl/e1_dip_pkg.sv
package e1_dip_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_FULL = 2'd1,
        ST_SLOT = 2'd2
    } dip_state_e;

endpackage

// File: rtl/e1_slot_timer.sv
module e1_slot_timer #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              frame_start_i,
    output logic [SLOT_W-1:0] pos_slot_o,
    output logic [BIT_W-1:0]  pos_bit_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;

    // the frame-start strobe forces the current bit to slot 0 bit 0
    always_comb begin
        pos_slot_o = frame_start_i ? '0 : slot_q;
        pos_bit_o  = frame_start_i ? '0 : bit_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else if (bit_en_i) begin
            if (pos_bit_o == LAST_BIT) begin
                bit_q  <= '0;
                slot_q <= (pos_slot_o == LAST_SLOT) ? '0 : pos_slot_o + 1'b1;
            end else begin
                bit_q  <= pos_bit_o + 1'b1;
                slot_q <= pos_slot_o;
            end
        end
    end

endmodule

// File: rtl/e1_dip_cfg.sv
module e1_dip_cfg #(
    parameter int              SLOT_W     = 5,
    parameter logic            RESET_SEL  = 1'b1,
    parameter logic [SLOT_W-1:0] RESET_SLOT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              pend_sel_o,
    output logic [SLOT_W-1:0] pend_slot_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sel_o  <= RESET_SEL;
            pend_slot_o <= RESET_SLOT;
        end else if (we_i) begin
            pend_sel_o  <= sel_i;
            pend_slot_o <= slot_i;
        end
    end

endmodule

// File: rtl/e1_dip_mode.sv
module e1_dip_mode
    import e1_dip_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              frame_start_i,
    input  logic              boundary_i,
    input  logic              pend_sel_i,
    input  logic [SLOT_W-1:0] pend_slot_i,
    output dip_state_e        state_o,
    output logic [SLOT_W-1:0] act_slot_o,
    output logic              full_mode_o,
    output logic              slot_mode_o,
    output logic [SLOT_W-1:0] eff_slot_o
);
    dip_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              reload;

    // next-state and reload decision
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        reload  = 1'b0;
        if (bit_en_i && boundary_i) begin
            unique case (state_q)
                ST_WAIT: reload = frame_start_i;
                ST_FULL: reload = 1'b1;
                ST_SLOT: reload = 1'b1;
                default: reload = 1'b0;
            endcase
        end
        if (reload) begin
            state_d = pend_sel_i ? ST_SLOT : ST_FULL;
            slot_d  = pend_slot_i;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // outputs: the mode in force for the bit being handled now
    always_comb begin
        full_mode_o = 1'b0;
        slot_mode_o = 1'b0;
        unique case (state_d)
            ST_WAIT: ;
            ST_FULL: full_mode_o = 1'b1;
            ST_SLOT: slot_mode_o = 1'b1;
            default: ;
        endcase
        eff_slot_o = slot_d;
        state_o    = state_q;
        act_slot_o = slot_q;
    end

endmodule

// File: rtl/e1_dip_path.sv
module e1_dip_path #(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              full_mode_i,
    input  logic              slot_mode_i,
    input  logic [SLOT_W-1:0] pos_slot_i,
    input  logic [SLOT_W-1:0] eff_slot_i,
    input  logic              rx_bit_i,
    input  logic              tx_bit_i,
    input  logic              aux_bit_i,
    output logic              drop_bit_o,
    output logic              drop_stb_o,
    output logic              ins_stb_o,
    output logic              tx_line_o
);
    logic hit;
    logic take;

    always_comb begin
        hit       = slot_mode_i && (pos_slot_i == eff_slot_i);
        take      = full_mode_i || hit;
        ins_stb_o = bit_en_i && hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_bit_o <= 1'b0;
            drop_stb_o <= 1'b0;
            tx_line_o  <= 1'b1;
        end else begin
            drop_stb_o <= bit_en_i && take;
            if (bit_en_i) begin
                if (take) begin
                    drop_bit_o <= rx_bit_i;
                end
                tx_line_o <= hit ? aux_bit_i : tx_bit_i;
            end
        end
    end

endmodule

// File: rtl/e1_dip_port.sv
module e1_dip_port
    import e1_dip_pkg::*;
#(
    parameter int   SLOTS      = 32,
    parameter int   SLOT_BITS  = 8,
    parameter logic RESET_SEL  = 1'b1,
    parameter int   RESET_SLOT = 0,
    localparam int  SLOT_W     = $clog2(SLOTS),
    localparam int  BIT_W      = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              frame_start_i,
    input  logic              rx_bit_i,
    input  logic              tx_bit_i,
    input  logic              aux_bit_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [SLOT_W-1:0] cfg_slot_i,
    output logic              drop_bit_o,
    output logic              drop_stb_o,
    output logic              ins_stb_o,
    output logic              tx_line_o
);
    logic [SLOT_W-1:0] pos_slot;
    logic [BIT_W-1:0]  pos_bit;
    logic              at_boundary;
    logic              pend_sel;
    logic [SLOT_W-1:0] pend_slot;
    dip_state_e        state_q;
    logic [SLOT_W-1:0] act_slot;
    logic              full_mode;
    logic              slot_mode;
    logic [SLOT_W-1:0] eff_slot;

    assign at_boundary = (pos_slot == '0) && (pos_bit == '0);

    e1_slot_timer #(
        .SLOTS     (SLOTS),
        .SLOT_BITS (SLOT_BITS)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_en_i      (bit_en_i),
        .frame_start_i (frame_start_i),
        .pos_slot_o    (pos_slot),
        .pos_bit_o     (pos_bit)
    );

    e1_dip_cfg #(
        .SLOT_W     (SLOT_W),
        .RESET_SEL  (RESET_SEL),
        .RESET_SLOT (SLOT_W'(RESET_SLOT))
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (cfg_we_i),
        .sel_i       (cfg_sel_i),
        .slot_i      (cfg_slot_i),
        .pend_sel_o  (pend_sel),
        .pend_slot_o (pend_slot)
    );

    e1_dip_mode #(
        .SLOT_W (SLOT_W)
    ) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_en_i      (bit_en_i),
        .frame_start_i (frame_start_i),
        .boundary_i    (at_boundary),
        .pend_sel_i    (pend_sel),
        .pend_slot_i   (pend_slot),
        .state_o       (state_q),
        .act_slot_o    (act_slot),
        .full_mode_o   (full_mode),
        .slot_mode_o   (slot_mode),
        .eff_slot_o    (eff_slot)
    );

    e1_dip_path #(
        .SLOT_W (SLOT_W)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en_i    (bit_en_i),
        .full_mode_i (full_mode),
        .slot_mode_i (slot_mode),
        .pos_slot_i  (pos_slot),
        .eff_slot_i  (eff_slot),
        .rx_bit_i    (rx_bit_i),
        .tx_bit_i    (tx_bit_i),
        .aux_bit_i   (aux_bit_i),
        .drop_bit_o  (drop_bit_o),
        .drop_stb_o  (drop_stb_o),
        .ins_stb_o   (ins_stb_o),
        .tx_line_o   (tx_line_o)
    );

endmodule

// File: rtl/e1_dip_port_chk.sv
module e1_dip_port_chk
    import e1_dip_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en_i,
    input logic              frame_start_i,
    input logic              drop_stb_o,
    input logic              ins_stb_o,
    input dip_state_e        state_q,
    input logic              at_boundary,
    input logic [SLOT_W-1:0] act_slot,
    input logic [SLOT_W-1:0] pos_slot,
    input logic [BIT_W-1:0]  pos_bit
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = '1;
    localparam logic [BIT_W-1:0]  LAST_BIT  = '1;

    // R1
    wait_no_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !frame_start_i) |-> !ins_stb_o);

    // R1
    wait_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !frame_start_i) |=> !drop_stb_o);

    // R3
    full_no_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !(bit_en_i && at_boundary)) |-> !ins_stb_o);

    // R5
    insert_slot_also_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_stb_o |=> drop_stb_o);

    // R6
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && pos_slot == LAST_SLOT && pos_bit == LAST_BIT)
        |=> (pos_slot == '0 && pos_bit == '0));

    // R7
    slot_held_mid_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en_i && at_boundary) |=> $stable(act_slot));

    // R8
    drop_follows_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_stb_o |-> $past(bit_en_i));

    // R8
    insert_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_stb_o |-> bit_en_i);

endmodule

bind e1_dip_port e1_dip_port_chk #(
    .SLOT_W (SLOT_W),
    .BIT_W  (BIT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en_i      (bit_en_i),
    .frame_start_i (frame_start_i),
    .drop_stb_o    (drop_stb_o),
    .ins_stb_o     (ins_stb_o),
    .state_q       (state_q),
    .at_boundary   (at_boundary),
    .act_slot      (act_slot),
    .pos_slot      (pos_slot),
    .pos_bit       (pos_bit)
);

// File: tb/e1_dip_port_bench.sv
module e1_dip_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en_i = 1'b0;
    logic       frame_start_i = 1'b0;
    logic       rx_bit_i = 1'b0;
    logic       tx_bit_i = 1'b0;
    logic       aux_bit_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_sel_i = 1'b0;
    logic [4:0] cfg_slot_i = '0;
    logic       drop_bit_o;
    logic       drop_stb_o;
    logic       ins_stb_o;
    logic       tx_line_o;

    int tests = 0;
    int fails = 0;

    // bench model of the port
    bit         m_started = 1'b0;
    bit         m_pend_sel = 1'b1;
    logic [4:0] m_pend_slot = 5'd0;
    int         m_mode = 0;     // 0 wait, 1 full, 2 single slot
    logic [4:0] m_slot = 5'd0;

    always #4 clk = ~clk;

    e1_dip_port u_e1_dip_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_en_i      (bit_en_i),
        .frame_start_i (frame_start_i),
        .rx_bit_i      (rx_bit_i),
        .tx_bit_i      (tx_bit_i),
        .aux_bit_i     (aux_bit_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_sel_i     (cfg_sel_i),
        .cfg_slot_i    (cfg_slot_i),
        .drop_bit_o    (drop_bit_o),
        .drop_stb_o    (drop_stb_o),
        .ins_stb_o     (ins_stb_o),
        .tx_line_o     (tx_line_o)
    );

    // {mode bit, slot[4:0], data salt[7:0]}
    localparam logic [13:0] VEC [6] = '{
        {1'b0, 5'd3,  8'h11},
        {1'b1, 5'd0,  8'h2C},
        {1'b1, 5'd31, 8'h47},
        {1'b1, 5'd5,  8'h93},
        {1'b1, 5'd17, 8'hE8},
        {1'b0, 5'd7,  8'h3B}
    };

    function automatic logic [7:0] rx_byte(input int s, input logic [7:0] salt);
        return 8'(s * 37) ^ salt;
    endfunction

    function automatic logic [7:0] tx_byte(input int s, input logic [7:0] salt);
        return ~(8'(s * 13) + salt);
    endfunction

    function automatic logic [7:0] aux_byte(input int s, input logic [7:0] salt);
        return 8'(s * 11) + salt + 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one 256-bit frame; write configuration at bit wr_at (-1 for none)
    task automatic run_frame(input bit fs, input int wr_at, input bit wsel,
                             input logic [4:0] wslot, input logic [7:0] salt,
                             input string tag);
        int         ndrop = 0;
        logic [7:0] cap = '0;
        string      req;
        for (int b = 0; b < 256; b++) begin
            int   s = b / 8;
            int   k = b % 8;
            logic rxb, txb, axb, hit, take;
            if (b == 0 && (fs || m_started)) begin
                m_started = 1'b1;
                m_mode    = m_pend_sel ? 2 : 1;
                m_slot    = m_pend_slot;
            end
            req = (m_mode == 0) ? "R1" : (m_mode == 1) ? "R3" : "R4";
            rxb = rx_byte(s, salt)[7-k];
            txb = tx_byte(s, salt)[7-k];
            axb = aux_byte(s, salt)[7-k];
            hit  = (m_mode == 2) && (5'(s) == m_slot);
            take = (m_mode == 1) || hit;
            @(negedge clk);
            rx_bit_i      = rxb;
            tx_bit_i      = txb;
            aux_bit_i     = axb;
            bit_en_i      = 1'b1;
            frame_start_i = (b == 0) && fs;
            cfg_we_i      = (b == wr_at);
            cfg_sel_i     = wsel;
            cfg_slot_i    = wslot;
            #1;
            chk(ins_stb_o == hit, {tag, " R5 insert strobe"}, 32'(ins_stb_o), 32'(hit));
            @(posedge clk);
            if (b == wr_at) begin
                m_pend_sel  = wsel;
                m_pend_slot = wslot;
            end
            @(negedge clk);
            bit_en_i      = 1'b0;
            frame_start_i = 1'b0;
            cfg_we_i      = 1'b0;
            chk(drop_stb_o == take, {tag, " ", req, " drop strobe"}, 32'(drop_stb_o), 32'(take));
            if (take && drop_stb_o) begin
                chk(drop_bit_o == rxb, {tag, " ", req, " drop bit"}, 32'(drop_bit_o), 32'(rxb));
                ndrop++;
                cap = {cap[6:0], drop_bit_o};
            end
            chk(tx_line_o == (hit ? axb : txb), {tag, " R5 tx line"},
                32'(tx_line_o), 32'(hit ? axb : txb));
            @(posedge clk);
            #1;
            chk(drop_stb_o == 1'b0, {tag, " R8 single-cycle strobe"}, 32'(drop_stb_o), 0);
        end
        chk(ndrop == ((m_mode == 2) ? 8 : (m_mode == 1) ? 256 : 0),
            {tag, " R4 drop count"}, 32'(ndrop),
            32'((m_mode == 2) ? 8 : (m_mode == 1) ? 256 : 0));
        if (m_mode == 2)
            chk(cap == rx_byte(int'(m_slot), salt), {tag, " R4 msb-first byte"},
                32'(cap), 32'(rx_byte(int'(m_slot), salt)));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state (R1)
        chk(drop_stb_o == 1'b0, "R1 reset drop strobe", 32'(drop_stb_o), 0);
        chk(ins_stb_o == 1'b0, "R1 reset insert strobe", 32'(ins_stb_o), 0);

        // no frame alignment yet: waiting state (R1)
        run_frame(1'b0, -1, 1'b0, 5'd0, 8'h61, "R1");
        chk(m_mode == 0, "R1 model still waiting", 32'(m_mode), 0);

        // first aligned frame uses the reset configuration 80h (R2)
        run_frame(1'b1, -1, 1'b0, 5'd0, 8'hA5, "R2");
        chk(m_mode == 2 && m_slot == 5'd0, "R2 reset config single slot 0",
            32'(m_slot), 0);

        // vector table: each write lands mid-frame and applies next frame
        foreach (VEC[i]) begin
            run_frame(1'b1, 40, VEC[i][13], VEC[i][12:8], VEC[i][7:0], "VEC");
        end
        run_frame(1'b1, -1, 1'b0, 5'd0, 8'h5D, "VEC");

        // R7: write on the same edge as the boundary bit -> next frame
        run_frame(1'b1, 0, 1'b1, 5'd9, 8'hC4, "R7 same-edge");
        chk(m_mode == 1, "R7 old mode kept on boundary write", 32'(m_mode), 1);
        // R7: write during the selected slot, bit 3 -> slot stays whole
        run_frame(1'b1, 75, 1'b1, 5'd2, 8'h77, "R7 in-slot");
        chk(m_slot == 5'd9, "R7 slot 9 in force", 32'(m_slot), 9);

        // R6: no frame-start strobe; counter wraps and new slot 2 applies
        run_frame(1'b0, -1, 1'b0, 5'd0, 8'h1F, "R6 wrap");
        chk(m_slot == 5'd2, "R6 slot after wrap", 32'(m_slot), 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule